// File: doc/BRIEF.md
# Prescaled Up-Counter Timer with One Compare Channel

This block is a small memory-mapped timer. An up-counter, whose width is chosen at build time as 16 or 32 bits, advances once per tick of a power-of-two prescaler. The counter wraps back to zero after it reaches a programmable modulo value, and each wrap raises an overflow flag. A single compare channel, when set to its software-compare mode, raises its own flag when the counter passes through a programmed compare value.

Software drives the block through a flat register bus made of a byte address, a write strobe, write data and combinational read data. Both flags are cleared by writing a one to them. Each flag has its own enable, and the enabled flags are combined into one level interrupt. A read-only register reports the counter width, so a single driver can serve both builds.

Top module: `pscnt_timer`

## Requirements
- R1: The read-only register at byte offset 0x04 returns the counter width in bits 23:16 (0x20 for 32 bits, 0x10 for 16 bits) and zeros elsewhere. Writes to it have no effect.
- R2: After reset, the control register (0x10), the counter (0x14), the channel control (0x20), the compare value (0x24) and the status register (0x1C) read 0. The modulo register (0x18) reads all ones of the counter width, and the interrupt output is low.
- R3: While control bit 3 is 1 and control bits 2:0 hold n, the counter adds one every 2^n clock cycles. The first increment lands 2^n cycles after the edge that wrote bit 3. n=7 gives divide-by-128.
- R4: While control bit 3 is 0, the counter holds its value.
- R5: On a tick where the counter equals the modulo value, the counter becomes 0 and the overflow flag (control bit 7) is set.
- R6: With the modulo at all ones, the counter runs freely through its maximum value and then to 0, setting the overflow flag.
- R7: A bus write to the counter register loads the written value on that edge and takes priority over a tick in the same cycle.
- R8: When the channel mode field (channel control bits 5:2) is 4, the channel flag (channel control bit 7) is set on the tick where the counter equals the compare value. In any other mode the flag is never set.
- R9: Writing 1 to bit 7 of the control register or the channel control register clears that flag. Writing 0 there leaves the flag unchanged.
- R10: The interrupt output is high exactly when some flag is set and its enable is set. The enable is bit 6 of the same register as the flag.
- R11: The status register at 0x1C is read-only. It shows the channel flag in bit 0 and the overflow flag in bit 8, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Level interrupt from the enabled flags |

## Verification
The embedded assertions check on every cycle how the counter steps. They confirm that it moves by exactly one on an ordinary tick, lands on zero and sets the overflow flag at the modulo value, stands still when stopped, and never sees two ticks in a row when the divisor is above one. They also check the set, clear and hold behaviour of each flag, and that the interrupt stays low while both enables are off. Only the directed scenarios can show the exact tick spacing for a given exponent, the register decoding and reset values, the read-only nature of the parameter and status registers, and the compare match landing on the expected cycle.

// File: rtl/pscnt_pkg.sv
package pscnt_pkg;

    localparam int BUS_W = 32;

    // Register byte offsets decoded by software
    localparam logic [7:0] OFS_PARAM  = 8'h04;
    localparam logic [7:0] OFS_CTRL   = 8'h10;
    localparam logic [7:0] OFS_COUNT  = 8'h14;
    localparam logic [7:0] OFS_MODULO = 8'h18;
    localparam logic [7:0] OFS_STATUS = 8'h1C;
    localparam logic [7:0] OFS_CHCTL  = 8'h20;
    localparam logic [7:0] OFS_CHVAL  = 8'h24;

    localparam logic [3:0] CH_MODE_SWCMP = 4'h4;

    localparam int FLG_OVF = 0;
    localparam int FLG_CH  = 1;
    localparam int NUM_FLG = 2;

    // Timer control register, bit 7 down to bit 0
    typedef struct packed {
        logic       flag;
        logic       ie;
        logic [1:0] rsvd;
        logic       run;
        logic [2:0] shift;
    } tmr_ctl_t;

    // Channel control register, bit 7 down to bit 0
    typedef struct packed {
        logic       flag;
        logic       ie;
        logic [3:0] mode;
        logic [1:0] rsvd;
    } ch_ctl_t;

    function automatic logic [BUS_W-1:0] low_ones(input int width);
        logic [BUS_W-1:0] m;
        m = '0;
        for (int i = 0; i < BUS_W; i++) begin
            if (i < width) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/pscnt_prescaler.sv
module pscnt_prescaler #(
    parameter int SHIFT_W = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic [SHIFT_W-1:0] shift,
    output logic               tick
);
    localparam int DIV_W = (1 << SHIFT_W) - 1;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] sel_mask;

    always_comb begin
        sel_mask = '0;
        for (int i = 0; i < DIV_W; i++) begin
            if (i < int'(shift)) sel_mask[i] = 1'b1;
        end
    end

    assign tick = run && ((div_q & sel_mask) == sel_mask);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
        (tick && shift != '0) |=> (shift == '0 || !tick)); // R3

endmodule

// File: rtl/pscnt_core.sv
module pscnt_core #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] modulo,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);
    logic [CNT_W-1:0] cnt_q;

    assign wrap  = tick && !load && (cnt_q == modulo);
    assign count = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (tick) begin
            if (cnt_q == modulo) cnt_q <= '0;
            else                 cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
        (tick && !load && cnt_q == modulo) |=> (cnt_q == '0)); // R5
    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (rst)
        (tick && !load && cnt_q != modulo) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1))); // R3
    AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (rst)
        (!run && !load) |=> $stable(cnt_q)); // R4
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt_q == $past(load_val))); // R7

endmodule

// File: rtl/pscnt_match.sv
module pscnt_match #(
    parameter int CNT_W = 32
) (
    input  logic             tick,
    input  logic [3:0]       mode,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] cmp_val,
    output logic             hit
);
    assign hit = tick && (mode == pscnt_pkg::CH_MODE_SWCMP) && (count == cmp_val);
endmodule

// File: rtl/pscnt_flag.sv
module pscnt_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst)      flag <= 1'b0;
        else if (set) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end

    AST_FLAG_SETS: assert property (@(posedge clk) disable iff (rst)
        set |=> flag); // R5
    AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (clr && !set) |=> !flag); // R9
    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!clr && !set) |=> $stable(flag)); // R9

endmodule

// File: rtl/pscnt_timer.sv
module pscnt_timer
    import pscnt_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int ADDR_W  = 8,
    parameter int SHIFT_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              irq
);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(low_ones(CNT_W));
    localparam logic [7:0]       WIDTH_ID = 8'(CNT_W);

    tmr_ctl_t         ctl_q, ctl_rd;
    ch_ctl_t          ch_q, ch_rd;
    logic [CNT_W-1:0] mod_q, cmp_q, count;
    logic             tick, wrap, hit;
    logic [NUM_FLG-1:0] flg_set, flg_clr, flg_q, flg_ie;

    function automatic logic hits(input logic [ADDR_W-1:0] a, input logic [7:0] ofs);
        return a == ADDR_W'(ofs);
    endfunction

    logic wr_ctl, wr_cnt, wr_mod, wr_ch, wr_val;
    assign wr_ctl = bus_we && hits(bus_addr, OFS_CTRL);
    assign wr_cnt = bus_we && hits(bus_addr, OFS_COUNT);
    assign wr_mod = bus_we && hits(bus_addr, OFS_MODULO);
    assign wr_ch  = bus_we && hits(bus_addr, OFS_CHCTL);
    assign wr_val = bus_we && hits(bus_addr, OFS_CHVAL);

    // Configuration storage
    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
            ch_q  <= '0;
            mod_q <= CNT_MAX;
            cmp_q <= '0;
        end else begin
            if (wr_ctl) begin
                ctl_q.shift <= bus_wdata[2:0];
                ctl_q.run   <= bus_wdata[3];
                ctl_q.ie    <= bus_wdata[6];
            end
            if (wr_ch) begin
                ch_q.mode <= bus_wdata[5:2];
                ch_q.ie   <= bus_wdata[6];
            end
            if (wr_mod) mod_q <= bus_wdata[CNT_W-1:0];
            if (wr_val) cmp_q <= bus_wdata[CNT_W-1:0];
        end
    end

    pscnt_prescaler #(.SHIFT_W(SHIFT_W)) u_psc (
        .clk   (clk),
        .rst   (rst),
        .run   (ctl_q.run),
        .shift (ctl_q.shift[SHIFT_W-1:0]),
        .tick  (tick)
    );

    pscnt_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst      (rst),
        .run      (ctl_q.run),
        .tick     (tick),
        .load     (wr_cnt),
        .load_val (bus_wdata[CNT_W-1:0]),
        .modulo   (mod_q),
        .count    (count),
        .wrap     (wrap)
    );

    pscnt_match #(.CNT_W(CNT_W)) u_match (
        .tick    (tick),
        .mode    (ch_q.mode),
        .count   (count),
        .cmp_val (cmp_q),
        .hit     (hit)
    );

    assign flg_set[FLG_OVF] = wrap;
    assign flg_clr[FLG_OVF] = wr_ctl && bus_wdata[7];
    assign flg_ie[FLG_OVF]  = ctl_q.ie;
    assign flg_set[FLG_CH]  = hit;
    assign flg_clr[FLG_CH]  = wr_ch && bus_wdata[7];
    assign flg_ie[FLG_CH]   = ch_q.ie;

    for (genvar g = 0; g < NUM_FLG; g++) begin : g_flag
        pscnt_flag u_flag (
            .clk  (clk),
            .rst  (rst),
            .set  (flg_set[g]),
            .clr  (flg_clr[g]),
            .flag (flg_q[g])
        );
    end

    assign irq = |(flg_q & flg_ie);

    // Read path
    always_comb begin
        ctl_rd       = ctl_q;
        ctl_rd.rsvd  = '0;
        ctl_rd.flag  = flg_q[FLG_OVF];
        ch_rd        = ch_q;
        ch_rd.rsvd   = '0;
        ch_rd.flag   = flg_q[FLG_CH];
        bus_rdata    = '0;
        if      (hits(bus_addr, OFS_PARAM))  bus_rdata[23:16] = WIDTH_ID;
        else if (hits(bus_addr, OFS_CTRL))   bus_rdata[7:0]   = ctl_rd;
        else if (hits(bus_addr, OFS_COUNT))  bus_rdata        = BUS_W'(count);
        else if (hits(bus_addr, OFS_MODULO)) bus_rdata        = BUS_W'(mod_q);
        else if (hits(bus_addr, OFS_STATUS)) begin
            bus_rdata[0] = flg_q[FLG_CH];
            bus_rdata[8] = flg_q[FLG_OVF];
        end
        else if (hits(bus_addr, OFS_CHCTL))  bus_rdata[7:0]   = ch_rd;
        else if (hits(bus_addr, OFS_CHVAL))  bus_rdata        = BUS_W'(cmp_q);
    end

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!ctl_q.ie && !ch_q.ie) |-> !irq); // R10
    AST_NO_CH_OUTSIDE_MODE: assert property (@(posedge clk) disable iff (rst)
        (ch_q.mode != CH_MODE_SWCMP && !flg_q[FLG_CH]) |=> !flg_q[FLG_CH]); // R8

    initial begin
        AST_WIDTH_OK: assert (CNT_W == 16 || CNT_W == 32); // R1
    end

endmodule

// File: tb/sim_pscnt_timer.sv
`timescale 1ns/1ps
module sim_pscnt_timer;
    localparam logic [7:0] A_PARAM = 8'h04, A_CTRL = 8'h10, A_CNT = 8'h14,
                           A_MOD = 8'h18, A_STAT = 8'h1C, A_CHC = 8'h20, A_CHV = 8'h24;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int total = 0;
    int bad   = 0;
    logic [31:0] v, v2;

    always #2.5 clk = ~clk;

    pscnt_timer u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a; bus_we = 1'b0;
        #1;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        rd(A_CTRL, v); check("R2 ctrl", v, 32'h0);
        rd(A_CNT, v);  check("R2 count", v, 32'h0);
        rd(A_MOD, v);  check("R2 modulo", v, 32'hFFFF_FFFF);
        rd(A_STAT, v); check("R2 status", v, 32'h0);
        rd(A_CHC, v);  check("R2 chctl", v, 32'h0);
        rd(A_CHV, v);  check("R2 chval", v, 32'h0);
        check("R2 irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_param();
        rd(A_PARAM, v); check("R1 width id", v, 32'h0020_0000);
        wr(A_PARAM, 32'hFFFF_FFFF);
        rd(A_PARAM, v); check("R1 write ignored", v, 32'h0020_0000);
    endtask

    task automatic t_prescale();
        wr(A_CNT, 0);
        wr(A_CTRL, 32'h0A);             // run, divide by 4
        repeat (3) @(negedge clk);
        rd(A_CNT, v); check("R3 div4 before first tick", v, 0);
        @(negedge clk);
        rd(A_CNT, v); check("R3 div4 first tick", v, 1);
        repeat (4) @(negedge clk);
        rd(A_CNT, v); check("R3 div4 second tick", v, 2);
        wr(A_CTRL, 0);
        wr(A_CNT, 0);
        wr(A_CTRL, 32'h08);             // run, divide by 1
        @(negedge clk);
        rd(A_CNT, v); check("R3 div1 one cycle", v, 1);
        repeat (4) @(negedge clk);
        rd(A_CNT, v); check("R3 div1 five cycles", v, 5);
        wr(A_CTRL, 0);
        wr(A_CNT, 0);
        wr(A_CTRL, 32'h0F);             // run, divide by 128
        repeat (127) @(negedge clk);
        rd(A_CNT, v); check("R3 div128 before tick", v, 0);
        @(negedge clk);
        rd(A_CNT, v); check("R3 div128 first tick", v, 1);
    endtask

    task automatic t_stop();
        wr(A_CTRL, 32'h07);             // stop, keep exponent
        rd(A_CNT, v);
        repeat (300) @(negedge clk);
        rd(A_CNT, v2); check("R4 held while stopped", v2, v);
    endtask

    task automatic t_modulo();
        wr(A_CTRL, 0);
        wr(A_CNT, 0);
        wr(A_MOD, 5);
        wr(A_CTRL, 32'h08);
        repeat (5) @(negedge clk);
        rd(A_CNT, v);  check("R5 at modulo", v, 5);
        rd(A_CTRL, v); check("R5 flag clear before wrap", v, 32'h08);
        @(negedge clk);
        rd(A_CNT, v);  check("R5 wrapped to zero", v, 0);
        rd(A_CTRL, v); check("R5 overflow flag", v, 32'h88);
        rd(A_STAT, v); check("R11 status overflow bit8", v, 32'h100);
        check("R10 irq off without enable", {31'b0, irq}, 0);
        wr(A_CTRL, 32'h00);
        rd(A_CTRL, v); check("R9 write zero keeps flag", v, 32'h80);
        wr(A_STAT, 32'hFFFF_FFFF);
        rd(A_STAT, v); check("R11 status write ignored", v, 32'h100);
        wr(A_CTRL, 32'h40);
        check("R10 irq with overflow enable", {31'b0, irq}, 1);
        wr(A_CTRL, 32'hC0);
        rd(A_CTRL, v); check("R9 overflow flag cleared", v, 32'h40);
        check("R10 irq drops after clear", {31'b0, irq}, 0);
        wr(A_CTRL, 0);
    endtask

    task automatic t_freerun();
        wr(A_MOD, 32'hFFFF_FFFF);
        wr(A_CNT, 32'hFFFF_FFFE);
        wr(A_CTRL, 32'h08);
        @(negedge clk);
        rd(A_CNT, v);  check("R6 reaches max", v, 32'hFFFF_FFFF);
        rd(A_CTRL, v); check("R6 no flag at max", v, 32'h08);
        @(negedge clk);
        rd(A_CNT, v);  check("R6 rolls to zero", v, 0);
        rd(A_CTRL, v); check("R6 flag on rollover", v, 32'h88);
        wr(A_CTRL, 32'h80);
    endtask

    task automatic t_load();
        wr(A_CNT, 0);
        wr(A_CTRL, 32'h08);
        repeat (3) @(negedge clk);
        wr(A_CNT, 100);
        rd(A_CNT, v); check("R7 load beats tick", v, 100);
        @(negedge clk);
        rd(A_CNT, v); check("R7 counts on from load", v, 101);
        wr(A_CTRL, 0);
    endtask

    task automatic t_compare();
        wr(A_CNT, 0);
        wr(A_CHV, 3);
        wr(A_CHC, 32'h50);              // software compare, enable
        wr(A_CTRL, 32'h08);
        repeat (3) @(negedge clk);
        rd(A_CHC, v); check("R8 no flag before match tick", v, 32'h50);
        check("R10 irq low before match", {31'b0, irq}, 0);
        @(negedge clk);
        rd(A_CHC, v);  check("R8 channel flag on match", v, 32'hD0);
        rd(A_STAT, v); check("R11 status channel bit0", v, 32'h1);
        check("R10 irq from channel", {31'b0, irq}, 1);
        wr(A_CTRL, 0);
        wr(A_CHC, 32'hD0);
        rd(A_CHC, v); check("R9 channel flag cleared", v, 32'h50);
        check("R10 irq low after channel clear", {31'b0, irq}, 0);
        wr(A_CHC, 32'h48);              // mode 2, enable
        wr(A_CNT, 0);
        wr(A_CTRL, 32'h08);
        repeat (10) @(negedge clk);
        rd(A_CHC, v); check("R8 other mode never flags", v, 32'h48);
        check("R8 irq quiet in other mode", {31'b0, irq}, 0);
        wr(A_CTRL, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_param();
        t_prescale();
        t_stop();
        t_modulo();
        t_freerun();
        t_load();
        t_compare();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(5ns * 100000);
        total++;
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule